// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers interrupt requests from 41 fixed sources and presents one request line to the processor. The sources are one non-maskable request, fifteen external request levels with fixed priorities, and twenty-five on-chip peripheral sources. Software sets the peripheral priorities through three 16-bit registers. Several peripherals share one 4-bit field, so they always carry the same level.

A one-cycle request pulse on a source line makes that source pending, provided its current priority is not zero. A priority-then-index arbiter picks one pending source from the live register contents. The block raises the processor request when the processor's block bit is clear and the picked level is strictly greater than the processor's mask level. When the processor accepts, the block presents the exception code of the picked source and clears its pending bit.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source numbering on `src_req` is as follows. Bit 0 is the non-maskable source, with level 16 and code 0x1C0. Bits 1..15 are external levels 0..14. External level n has level 15-n and code 0x200+0x20*n. Bits 16..40 are peripherals k=0..24. Peripherals k=0..13 have codes 0x400+0x20*k. Peripherals k=14..20 have codes 0x600+0x20*(k-14). Peripherals k=21..24 have codes 0x700+0x20*(k-21).
- R2: Register A is at address 0. Bits 15:12 give the level of peripheral k=0 and bits 11:8 give k=1. Bits 7:4 are shared by k=2..3, and bits 3:0 are shared by k=4..6.
- R3: Register B is at address 1. Bits 7:4 are shared by k=7..10, bits 15:12 give k=11, and bits 11:8 are shared by k=12..13. Bits 3:0 are stored but set no level.
- R4: Register C is at address 2. Bits 3:0 give k=14 and bits 15:12 give k=15. Bits 11:8 are shared by k=16..20, and bits 7:4 are shared by k=21..24.
- R5: `bus_rdata` shows the stored value of the register that `bus_addr` selects. Addresses other than 0..2 read as zero. A write to any such other address changes no state.
- R6: A request that arrives while the source's level is zero is discarded. The source does not become pending, even if its level is raised later.
- R7: A second request from a source that is already pending is not recorded. A single accept clears that source.
- R8: The arbiter picks the pending source with the highest level. When levels are equal, it picks the lower source number. `ack_code` shows the picked source's code, or zero when nothing is pending.
- R9: `irq_out` is high only when `cpu_block` is 0 and the picked level is strictly greater than `cpu_mask`. It follows changes of `cpu_mask` and `cpu_block` in the same cycle.
- R10: When `ack_in` is high in a cycle, `ack_code` holds the picked source's code, and that source stops being pending at the next clock edge. A new request from the same source in that same cycle keeps it pending.
- R11: Synchronous active-high `rst` clears all pending sources and the three registers, and `irq_out` reads 0.
- R12: A level change written to a register affects the selection from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 41 | One-cycle request pulse per source |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| cpu_mask | input | 4 | Processor mask level |
| cpu_block | input | 1 | Processor block bit |
| irq_out | output | 1 | Interrupt request to the processor |
| ack_in | input | 1 | Processor accept strobe |
| ack_code | output | 12 | Exception code of the picked source |

## Verification
Several properties are checked on every clock cycle:
- A pending bit never rises for a source whose level was zero.
- The picked source is always pending and has a nonzero level.
- `irq_out` never rises while blocked or with nothing picked.
- An accept clears the picked source.
- A register write is stored.
- Reset leaves nothing pending.

Some behaviours can only be shown by the bench's scenarios:
- The actual field-to-source wiring and the code values.
- The order in which sources come out when several are pending.
- The strict mask comparison at its boundary.
- That a discarded request stays lost after its level is raised.
- The next-cycle effect of a level change.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NUM_SRC  = 41;
    localparam int NUM_EXT  = 15;
    localparam int PER_BASE = NUM_EXT + 1;
    localparam int NUM_PER  = NUM_SRC - PER_BASE;
    localparam int FW       = 4;
    localparam int PW       = FW + 1;
    localparam int CODE_W   = 12;
    localparam int IDX_W    = $clog2(NUM_SRC);
    localparam int REG_W    = 16;
    localparam int ADDR_W   = 4;
    localparam int NUM_BANK = 3;
    localparam int NMI_PRIO = 16;

    typedef logic [PW-1:0]     prio_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [1:0] {BANK_A = 2'd0, BANK_B = 2'd1, BANK_C = 2'd2} bank_e;

    typedef struct packed {
        bank_e      bank;
        logic [1:0] nib;
    } field_t;

    typedef struct packed {
        logic  valid;
        idx_t  idx;
        prio_t prio;
    } pick_t;

    // Register field that sets the level of peripheral k.
    function automatic field_t per_field(input int k);
        field_t f;
        if (k == 0)       f = '{BANK_A, 2'd3};
        else if (k == 1)  f = '{BANK_A, 2'd2};
        else if (k <= 3)  f = '{BANK_A, 2'd1};
        else if (k <= 6)  f = '{BANK_A, 2'd0};
        else if (k <= 10) f = '{BANK_B, 2'd1};
        else if (k == 11) f = '{BANK_B, 2'd3};
        else if (k <= 13) f = '{BANK_B, 2'd2};
        else if (k == 14) f = '{BANK_C, 2'd0};
        else if (k == 15) f = '{BANK_C, 2'd3};
        else if (k <= 20) f = '{BANK_C, 2'd2};
        else              f = '{BANK_C, 2'd1};
        return f;
    endfunction

    // Fixed level of the non-maskable and external sources.
    function automatic prio_t fixed_prio(input int i);
        return (i == 0) ? prio_t'(NMI_PRIO) : prio_t'(NMI_PRIO - i);
    endfunction

    // Exception code of source i.
    function automatic code_t src_code(input int i);
        int k;
        k = i - PER_BASE;
        if (i == 0)       return code_t'(12'h1C0);
        else if (i < PER_BASE) return code_t'(12'h200 + 12'h20 * (i - 1));
        else if (k < 14)  return code_t'(12'h400 + 12'h20 * k);
        else if (k < 21)  return code_t'(12'h600 + 12'h20 * (k - 14));
        else              return code_t'(12'h700 + 12'h20 * (k - 21));
    endfunction
endpackage

// File: rtl/pic_prio_regs.sv
module pic_prio_regs
    import pic_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [REG_W-1:0]             wdata,
    output logic [REG_W-1:0]             rdata,
    output logic [NUM_SRC-1:0][PW-1:0]   prio_vec
);
    logic [NUM_BANK-1:0][REG_W-1:0] bank_q;
    logic addr_hit;

    assign addr_hit = (addr < ADDR_W'(NUM_BANK));

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else if (we && addr_hit) begin
            bank_q[addr[1:0]] <= wdata;
        end
    end

    assign rdata = addr_hit ? bank_q[addr[1:0]] : '0;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_prio
        if (g < PER_BASE) begin : g_fixed
            assign prio_vec[g] = fixed_prio(g);
        end else begin : g_field
            localparam field_t F = per_field(g - PER_BASE);
            localparam int     B = int'(F.bank);
            localparam int     L = int'(F.nib) * FW;
            assign prio_vec[g] = {1'b0, bank_q[B][L +: FW]};
        end
    end

    assert_reg_write_R5: assert property (@(posedge clk) disable iff (rst)
        (we && addr == '0) |=> (bank_q[0] == $past(wdata)));
endmodule

// File: rtl/pic_pending.sv
module pic_pending
    import pic_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_SRC-1:0]           set_req,
    input  logic [NUM_SRC-1:0][PW-1:0]   prio_vec,
    input  logic                         retire_en,
    input  idx_t                         retire_idx,
    output logic [NUM_SRC-1:0]           pend_q
);
    logic [NUM_SRC-1:0] nz_mask;
    logic [NUM_SRC-1:0] retire_mask;

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            nz_mask[i]     = (prio_vec[i] != '0);
            retire_mask[i] = retire_en && (retire_idx == idx_t'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~retire_mask) | (set_req & nz_mask);
    end

    assert_drop_zero_prio_R6: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & ~$past(pend_q) & ~$past(nz_mask)) == '0));
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
(
    input  logic [NUM_SRC-1:0]           pend,
    input  logic [NUM_SRC-1:0][PW-1:0]   prio_vec,
    output pick_t                        pick
);
    always_comb begin
        pick = '0;
        // Scan downwards with >= so that the lowest index wins a tie.
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i] && prio_vec[i] != '0 && prio_vec[i] >= pick.prio) begin
                pick.valid = 1'b1;
                pick.idx   = idx_t'(i);
                pick.prio  = prio_vec[i];
            end
        end
    end

    always_comb begin
        if (pick.valid) begin
            assert_sel_pending_R8: assert (pend[pick.idx] && prio_vec[pick.idx] != '0);
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_SRC-1:0]    src_req,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [REG_W-1:0]      bus_wdata,
    output logic [REG_W-1:0]      bus_rdata,
    input  logic [FW-1:0]         cpu_mask,
    input  logic                  cpu_block,
    output logic                  irq_out,
    input  logic                  ack_in,
    output logic [CODE_W-1:0]     ack_code
);
    logic [NUM_SRC-1:0][PW-1:0]     prio_vec;
    logic [NUM_SRC-1:0]             pend_q;
    logic [NUM_SRC-1:0][CODE_W-1:0] code_tab;
    pick_t                          pick;
    logic                           retire_en;

    pic_prio_regs u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .prio_vec(prio_vec)
    );

    pic_pending u_pend (
        .clk(clk), .rst(rst), .set_req(src_req), .prio_vec(prio_vec),
        .retire_en(retire_en), .retire_idx(pick.idx), .pend_q(pend_q)
    );

    pic_arbiter u_arb (
        .pend(pend_q), .prio_vec(prio_vec), .pick(pick)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_code
        assign code_tab[g] = src_code(g);
    end

    assign retire_en = ack_in && pick.valid;
    assign ack_code  = pick.valid ? code_tab[pick.idx] : '0;
    assign irq_out   = pick.valid && !cpu_block && (pick.prio > {1'b0, cpu_mask});

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (!cpu_block && ack_code != '0));

    assert_retire_R10: assert property (@(posedge clk) disable iff (rst)
        (retire_en && !src_req[pick.idx]) |=> !pend_q[$past(pick.idx)]);

    assert_reset_clear_R11: assert property (@(posedge clk)
        $past(rst) |-> (pend_q == '0 && !irq_out));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
    import pic_pkg::*;

    logic               clk = 1'b0;
    logic               rst;
    logic [NUM_SRC-1:0] src_req;
    logic               bus_we;
    logic [ADDR_W-1:0]  bus_addr;
    logic [REG_W-1:0]   bus_wdata;
    logic [REG_W-1:0]   bus_rdata;
    logic [FW-1:0]      cpu_mask;
    logic               cpu_block;
    logic               irq_out;
    logic               ack_in;
    logic [CODE_W-1:0]  ack_code;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst(rst), .src_req(src_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_mask(cpu_mask), .cpu_block(cpu_block), .irq_out(irq_out),
        .ack_in(ack_in), .ack_code(ack_code)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic edge1();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int a, input int d);
        bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = REG_W'(d);
        edge1();
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string req);
        bus_addr = ADDR_W'(a);
        #1;
        chk(bus_rdata == REG_W'(exp), req, "readback", bus_rdata, exp);
    endtask

    task automatic raise(input logic [NUM_SRC-1:0] v);
        src_req = v;
        edge1();
        src_req = '0;
    endtask

    task automatic peek(input int exp, input string req);
        #1;
        chk(ack_code == CODE_W'(exp), req, "selected code", ack_code, exp);
    endtask

    task automatic chk_irq(input bit exp, input string req);
        #1;
        chk(irq_out == exp, req, "irq_out", irq_out, exp);
    endtask

    task automatic accept(input int exp, input string req);
        ack_in = 1'b1;
        #1;
        chk(ack_code == CODE_W'(exp), req, "accepted code", ack_code, exp);
        edge1();
        ack_in = 1'b0;
    endtask

    function automatic logic [NUM_SRC-1:0] bit_of(input int i);
        logic [NUM_SRC-1:0] v;
        v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    task automatic t_reset_state();
        chk_irq(1'b0, "R11");
        peek(0, "R11");
        rd(0, 0, "R11");
    endtask

    task automatic t_registers();
        wr(0, 16'h1234); wr(1, 16'hABCD); wr(2, 16'h5A5A);
        wr(3, 16'hFFFF); wr(15, 16'hFFFF);
        rd(0, 16'h1234, "R5");
        rd(1, 16'hABCD, "R5");
        rd(2, 16'h5A5A, "R5");
        rd(3, 0, "R5");
        wr(0, 0); wr(1, 0); wr(2, 0);
    endtask

    task automatic t_zero_drop();
        raise(bit_of(16));
        wr(0, 16'hF000);
        peek(0, "R6");
        chk_irq(1'b0, "R6");
        wr(0, 0);
    endtask

    task automatic t_fixed_sources();
        raise(bit_of(15) | bit_of(1));
        peek(12'h200, "R8");
        chk_irq(1'b1, "R9");
        raise(bit_of(0));
        peek(12'h1C0, "R1");
        accept(12'h1C0, "R1");
        accept(12'h200, "R10");
        accept(12'h3C0, "R1");
        peek(0, "R10");
        chk_irq(1'b0, "R10");
    endtask

    task automatic t_mask();
        raise(bit_of(6));
        cpu_mask = 4'd10; chk_irq(1'b0, "R9");
        cpu_mask = 4'd9;  chk_irq(1'b1, "R9");
        cpu_block = 1'b1; chk_irq(1'b0, "R9");
        cpu_block = 1'b0; cpu_mask = 4'd15;
        raise(bit_of(0));
        chk_irq(1'b1, "R9");
        cpu_block = 1'b1; chk_irq(1'b0, "R9");
        cpu_block = 1'b0; cpu_mask = 4'd0;
        accept(12'h1C0, "R10");
        accept(12'h2A0, "R10");
    endtask

    task automatic t_bank_a_tie();
        wr(0, 16'h5555);
        raise(bit_of(19) | bit_of(22));
        peek(12'h460, "R8");
        wr(0, 16'h5556);
        peek(12'h4C0, "R12");
        accept(12'h4C0, "R2");
        accept(12'h460, "R2");
        peek(0, "R2");
    endtask

    task automatic t_bank_b();
        wr(1, 16'h0007);
        raise(bit_of(26) | bit_of(27) | bit_of(29));
        peek(0, "R3");
        wr(1, 16'h39A7);
        raise(bit_of(26) | bit_of(27) | bit_of(29));
        accept(12'h540, "R3");
        accept(12'h5A0, "R3");
        accept(12'h560, "R3");
        peek(0, "R3");
    endtask

    task automatic t_bank_c();
        wr(2, 16'h4C82);
        raise(bit_of(30) | bit_of(31) | bit_of(36) | bit_of(40));
        accept(12'h6C0, "R4");
        accept(12'h760, "R4");
        accept(12'h620, "R4");
        accept(12'h600, "R4");
        peek(0, "R4");
    endtask

    task automatic t_duplicate();
        raise(bit_of(4));
        raise(bit_of(4));
        accept(12'h260, "R7");
        peek(0, "R7");
        chk_irq(1'b0, "R7");
    endtask

    task automatic t_reset_mid();
        raise(bit_of(1));
        chk_irq(1'b1, "R11");
        rst = 1'b1;
        edge1();
        rst = 1'b0;
        chk_irq(1'b0, "R11");
        peek(0, "R11");
        rd(0, 0, "R11");
    endtask

    initial begin
        rst = 1'b1; src_req = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        cpu_mask = '0; cpu_block = 1'b0; ack_in = 1'b0;
        edge1(); edge1();
        rst = 1'b0;
        t_reset_state();
        t_registers();
        t_zero_drop();
        t_fixed_sources();
        t_mask();
        t_bank_a_tie();
        t_bank_b();
        t_bank_c();
        t_duplicate();
        t_reset_mid();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 0x1 expected 0x0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule